// File: doc/BRIEF.md
# Multi-Channel Match Timer Bank

This block holds eight timer channels, numbered 4 to 11. Each channel has a 32-bit up-counter, a 32-bit compare value and a mode word. The mode word picks which of four external rate pulses advances the counter. It also sets what a compare hit does: the counter can wrap to zero on a hit, and the channel can either keep producing hits or stop after the first one. Channels 5 and 7 can also compare against the counter of their lower neighbour (4 or 6) instead of their own.

A hit sets the channel's bit in a sticky event register, provided the channel's enable bit is set. Event bits are cleared by writing ones to them. A single interrupt line is high while any event bit is set. A capture register can take a copy of counter 8 or counter 10 at the moment software reads counter 9 or counter 11. The block does not generate the rate pulses itself. Each one arrives on its own input as a one-cycle pulse.

Top module: `tmr_match_bank`

## Requirements
- R1: Mode bits 2:0 pick the source that advances the counter by one per pulse: code 1 uses `tick_en[0]`, 2 uses `tick_en[1]`, 3 uses `tick_en[2]` and 4 uses `tick_en[3]`. Codes 0, 5, 6 and 7 stop the counter, and it keeps its value.
- R2: Mode words of channels 4 to 7 keep only write bits 7:0. Those of channels 8 to 11 keep bits 9:0. All other bits read back as zero.
- R3: With mode bit 3 set, a hit on a channel that uses its own counter loads zero into that counter instead of the compare value.
- R4: A hit happens on the pulse that advances the compared counter to the compare value. With mode bit 6 set, the channel keeps producing hits. With bit 6 clear, it produces no more hits until its compare value or mode word is written again.
- R5: With mode bit 7 clear, channels 5 and 7 compare against counter 4 and counter 6 respectively, and their own counters hold. With bit 7 set, they count and compare on their own counters. All other channels always use their own counter.
- R6: On channels 8 to 11, mode bit 8 stops the counter whatever bits 2:0 hold.
- R7: A read of counter 9 (0x54) or counter 11 (0x5C) while that channel's mode bit 9 is set copies counter 8 or counter 10 into the capture register at 0x20. A read without bit 9 leaves the capture register unchanged.
- R8: A hit sets event bit (channel number) at 0x24 only when enable bit (channel number) at 0x28 is set. Writing ones to 0x24 clears those bits. `irq` is high exactly while any event bit 11:4 is set.
- R9: The registers of channel c sit at 0x40+4(c-4) for the counter, 0x80+4(c-4) for the compare value and 0xC0+4(c-4) for the mode word.
- R10: A counter write loads the written value, and it takes priority over a pulse in the same cycle. Writing a mode word leaves the counter value unchanged.
- R11: After reset, every register reads zero and `irq` is low. Read data appears on `bus_rdata` one cycle after `bus_rd`, and an unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tick_en | input | 4 | One-cycle rate pulses, codes 1 to 4 |
| irq | output | 1 | Combined interrupt, high while any event bit is set |

## Verification
Register writes, counter steps, event bits and `irq` all change on the clock edge that samples the write strobe or the rate pulse. So a check made at the next falling edge already sees the new value. Read data is registered once, and it is sampled at the falling edge that follows the read cycle. The capture register is loaded on that same read edge. The bench drives every strobe and pulse at a falling edge for exactly one cycle. It therefore always samples one full cycle after the edge that should have produced the result.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned NCH         = 8;
  localparam int unsigned FIRST_CH    = 4;
  localparam int unsigned CTRL_NARROW = 8;
  localparam int unsigned CTRL_WIDE   = 10;

  // mode word bit positions
  localparam int unsigned RST_BIT    = 3;
  localparam int unsigned PER_BIT    = 6;
  localparam int unsigned OWN_BIT    = 7;
  localparam int unsigned FREEZE_BIT = 8;
  localparam int unsigned SNAP_BIT   = 9;

  // register bases
  localparam logic [ADDR_W-1:0] A_SNAP  = 8'h20;
  localparam logic [ADDR_W-1:0] A_EVENT = 8'h24;
  localparam logic [ADDR_W-1:0] A_ENAB  = 8'h28;
  localparam logic [ADDR_W-1:0] A_CNT   = 8'h40;
  localparam logic [ADDR_W-1:0] A_CMP   = 8'h80;
  localparam logic [ADDR_W-1:0] A_MODE  = 8'hC0;

  function automatic logic [ADDR_W-1:0] reg_addr(input logic [ADDR_W-1:0] base,
                                                 input int unsigned idx);
    return base + ADDR_W'(idx * 4);
  endfunction
endpackage

// File: rtl/tmr_rate_sel.sv
module tmr_rate_sel #(
  parameter int unsigned NRATE = 4
) (
  input  logic [2:0]       code,
  input  logic             freeze,
  input  logic [NRATE-1:0] tick_en,
  output logic             pulse
);
  always_comb begin
    pulse = 1'b0;
    if (!freeze && code != 3'd0 && int'(code) <= NRATE)
      pulse = tick_en[code - 3'd1];
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CTRLW = 8,
  parameter int unsigned NRATE = 4,
  parameter bit          SHARE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NRATE-1:0] tick_en,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic             mode_wr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    src_cnt_i,
  input  logic             src_step_i,
  output logic [DW-1:0]    cnt_o,
  output logic [DW-1:0]    cmp_o,
  output logic [CTRLW-1:0] mode_o,
  output logic             step_o,
  output logic             hit_o
);
  logic [CTRLW-1:0] mode_q, mode_d;
  logic [DW-1:0]    cmp_q, cmp_d, cnt_q, cnt_d, cmp_cnt;
  logic             armed_q, armed_d;
  logic             freeze, use_own, rate_pulse, cmp_step;

  generate
    if (CTRLW > FREEZE_BIT) begin : g_frz
      assign freeze = mode_q[FREEZE_BIT];
    end else begin : g_nofrz
      assign freeze = 1'b0;
    end
    if (SHARE) begin : g_share
      assign use_own = mode_q[OWN_BIT];
    end else begin : g_solo
      assign use_own = 1'b1;
    end
  endgenerate

  tmr_rate_sel #(.NRATE(NRATE)) u_rate (
    .code   (mode_q[2:0]),
    .freeze (freeze),
    .tick_en(tick_en),
    .pulse  (rate_pulse)
  );

  always_comb begin
    step_o   = rate_pulse && use_own && !cnt_wr;
    cmp_cnt  = use_own ? cnt_q  : src_cnt_i;
    cmp_step = use_own ? step_o : src_step_i;
    hit_o    = armed_q && cmp_step && ((cmp_cnt + 1'b1) == cmp_q);

    cnt_d = cnt_q;
    if (cnt_wr)
      cnt_d = wdata;
    else if (step_o)
      cnt_d = (hit_o && mode_q[RST_BIT]) ? '0 : cnt_q + 1'b1;

    mode_d = mode_wr ? wdata[CTRLW-1:0] : mode_q;
    cmp_d  = cmp_wr  ? wdata : cmp_q;

    armed_d = armed_q;
    if (cmp_wr || mode_wr)
      armed_d = 1'b1;
    else if (hit_o && !mode_q[PER_BIT])
      armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      cmp_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      mode_q  <= mode_d;
      cmp_q   <= cmp_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign cmp_o  = cmp_q;
  assign mode_o = mode_q;

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !rate_pulse) |=> $stable(cnt_q));

  a_r3_zero_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && use_own && mode_q[RST_BIT] && !cnt_wr) |=> (cnt_q == '0));

  a_r4_single_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !mode_q[PER_BIT] && !cmp_wr && !mode_wr) |=> !armed_q);

  generate
    if (SHARE) begin : g_share_chk
      a_r5_borrowed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[OWN_BIT] && !cnt_wr) |=> $stable(cnt_q));
    end
  endgenerate
endmodule

// File: rtl/tmr_event_ctl.sv
module tmr_event_ctl #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit_i,
  input  logic           en_wr,
  input  logic           ev_wr,
  input  logic [NCH-1:0] bits_i,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] ev_o,
  output logic           irq_o
);
  logic [NCH-1:0] en_q, en_d, ev_q, ev_d, clr;

  always_comb begin
    clr  = ev_wr ? bits_i : '0;
    ev_d = (ev_q & ~clr) | (hit_i & en_q);
    en_d = en_wr ? bits_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      ev_q <= '0;
    end else begin
      en_q <= en_d;
      ev_q <= ev_d;
    end
  end

  assign en_o  = en_q;
  assign ev_o  = ev_q;
  assign irq_o = |ev_q;

  a_r8_hit_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_i & en_q)) |=> irq_o);

  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr && ((ev_q & ~bits_i) == '0) && !(|(hit_i & en_q))) |=> !irq_o);
endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank
  import tmr_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned NRATE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NRATE-1:0]  tick_en,
  output logic              irq
);
  localparam int unsigned HALF = NCH / 2;

  logic [DW-1:0]  cnt_arr  [NCH];
  logic [DW-1:0]  cmp_arr  [NCH];
  logic [DW-1:0]  mode_arr [NCH];
  logic [NCH-1:0] step_v, hit_v, en_v, ev_v;
  logic [DW-1:0]  snap_q, snap_d, rdata_q, rdata_d;
  logic           en_sel, ev_sel;

  assign en_sel = bus_wr && (bus_addr == A_ENAB);
  assign ev_sel = bus_wr && (bus_addr == A_EVENT);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int unsigned CW_I = (i < HALF) ? CTRL_NARROW : CTRL_WIDE;
      localparam bit          SH_I = (i == 1) || (i == 3);
      logic [CW_I-1:0] mode_w;
      logic [DW-1:0]   src_cnt;
      logic            src_step;

      if (SH_I) begin : g_pair
        assign src_cnt  = cnt_arr[i-1];
        assign src_step = step_v[i-1];
      end else begin : g_nopair
        assign src_cnt  = '0;
        assign src_step = 1'b0;
      end

      tmr_channel #(
        .DW(DW), .CTRLW(CW_I), .NRATE(NRATE), .SHARE(SH_I)
      ) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .cnt_wr    (bus_wr && bus_addr == reg_addr(A_CNT, i)),
        .cmp_wr    (bus_wr && bus_addr == reg_addr(A_CMP, i)),
        .mode_wr   (bus_wr && bus_addr == reg_addr(A_MODE, i)),
        .wdata     (bus_wdata),
        .src_cnt_i (src_cnt),
        .src_step_i(src_step),
        .cnt_o     (cnt_arr[i]),
        .cmp_o     (cmp_arr[i]),
        .mode_o    (mode_w),
        .step_o    (step_v[i]),
        .hit_o     (hit_v[i])
      );
      assign mode_arr[i] = DW'(mode_w);
    end
  endgenerate

  tmr_event_ctl #(.NCH(NCH)) u_events (
    .clk   (clk),
    .rst_n (rst_n),
    .hit_i (hit_v),
    .en_wr (en_sel),
    .ev_wr (ev_sel),
    .bits_i(bus_wdata[FIRST_CH +: NCH]),
    .en_o  (en_v),
    .ev_o  (ev_v),
    .irq_o (irq)
  );

  // capture: reading an odd upper counter copies its lower neighbour
  always_comb begin
    snap_d = snap_q;
    for (int i = HALF; i < NCH; i++) begin
      if ((i % 2) == 1 && bus_rd && bus_addr == reg_addr(A_CNT, i) &&
          mode_arr[i][SNAP_BIT])
        snap_d = cnt_arr[(i > 0) ? i - 1 : 0];
    end
  end

  always_comb begin
    rdata_d = '0;
    if (bus_addr == A_SNAP)  rdata_d = snap_q;
    if (bus_addr == A_EVENT) rdata_d[FIRST_CH +: NCH] = ev_v;
    if (bus_addr == A_ENAB)  rdata_d[FIRST_CH +: NCH] = en_v;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == reg_addr(A_CNT, i))  rdata_d = cnt_arr[i];
      if (bus_addr == reg_addr(A_CMP, i))  rdata_d = cmp_arr[i];
      if (bus_addr == reg_addr(A_MODE, i)) rdata_d = mode_arr[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else begin
      snap_q <= snap_d;
      if (bus_rd)
        rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  a_r7_snap_on_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(snap_q));
endmodule

// File: tb/tmr_match_bank_bench.sv
module tmr_match_bank_bench;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2, OP_I = 2'd3;
  localparam int NV = 64;

  // {req[3:0], op[1:0], addr[7:0], data[31:0], exp[31:0]}
  localparam logic [77:0] VEC [NV] = '{
    {4'd2, OP_W, 8'hC4, 32'hFFFFFFFF, 32'h0},   // R2 ch5 mode
    {4'd2, OP_R, 8'hC4, 32'h0, 32'h000000FF},   // R2
    {4'd2, OP_W, 8'hD0, 32'hFFFFFFFF, 32'h0},   // R2 ch8 mode
    {4'd2, OP_R, 8'hD0, 32'h0, 32'h000003FF},   // R2
    {4'd2, OP_W, 8'hD0, 32'h0, 32'h0},
    {4'd2, OP_W, 8'hC4, 32'h0, 32'h0},
    {4'd8, OP_W, 8'h28, 32'h00000FF0, 32'h0},   // R8 enable all
    {4'd1, OP_W, 8'hC0, 32'h1, 32'h0},          // R1 code1
    {4'd1, OP_T, 8'h00, 32'h2, 32'h0},
    {4'd1, OP_R, 8'h40, 32'h0, 32'h0},          // R1 other source ignored
    {4'd1, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd1, OP_R, 8'h40, 32'h0, 32'h1},
    {4'd1, OP_W, 8'hC0, 32'h4, 32'h0},          // R1 code4
    {4'd1, OP_T, 8'h00, 32'h8, 32'h0},
    {4'd1, OP_R, 8'h40, 32'h0, 32'h2},
    {4'd1, OP_W, 8'hC0, 32'h3, 32'h0},          // R1 code3
    {4'd1, OP_T, 8'h00, 32'h4, 32'h0},
    {4'd1, OP_R, 8'h40, 32'h0, 32'h3},
    {4'd1, OP_W, 8'hC0, 32'h2, 32'h0},          // R1 code2
    {4'd1, OP_T, 8'h00, 32'h2, 32'h0},
    {4'd1, OP_R, 8'h40, 32'h0, 32'h4},
    {4'd1, OP_W, 8'hC0, 32'h5, 32'h0},          // R1 code5 stopped
    {4'd1, OP_T, 8'h00, 32'hF, 32'h0},
    {4'd1, OP_R, 8'h40, 32'h0, 32'h4},
    {4'd10, OP_W, 8'h40, 32'h10, 32'h0},        // R10 load
    {4'd10, OP_R, 8'h40, 32'h0, 32'h10},
    {4'd10, OP_W, 8'hC0, 32'h41, 32'h0},        // R10 mode write
    {4'd10, OP_R, 8'h40, 32'h0, 32'h10},
    {4'd9, OP_W, 8'h80, 32'h12, 32'h0},         // R9 compare ch4
    {4'd9, OP_R, 8'h80, 32'h0, 32'h12},
    {4'd8, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd8, OP_I, 8'h00, 32'h0, 32'h0},          // R8 no hit yet
    {4'd8, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd8, OP_R, 8'h24, 32'h0, 32'h10},         // R8 event bit4
    {4'd8, OP_I, 8'h00, 32'h0, 32'h1},
    {4'd8, OP_W, 8'h24, 32'h10, 32'h0},
    {4'd8, OP_I, 8'h00, 32'h0, 32'h0},          // R8 cleared
    {4'd8, OP_W, 8'hC0, 32'h0, 32'h0},
    {4'd3, OP_W, 8'h88, 32'h3, 32'h0},          // R3 ch6
    {4'd3, OP_W, 8'hC8, 32'h49, 32'h0},
    {4'd3, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd3, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd3, OP_R, 8'h48, 32'h0, 32'h2},
    {4'd3, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd3, OP_R, 8'h48, 32'h0, 32'h0},          // R3 wrapped to zero
    {4'd4, OP_R, 8'h24, 32'h0, 32'h40},
    {4'd4, OP_W, 8'h24, 32'h40, 32'h0},
    {4'd4, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd4, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd4, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd4, OP_R, 8'h24, 32'h0, 32'h40},         // R4 periodic again
    {4'd4, OP_W, 8'h24, 32'h40, 32'h0},
    {4'd4, OP_W, 8'hC8, 32'h0, 32'h0},
    {4'd4, OP_W, 8'h90, 32'h2, 32'h0},          // R4 ch8 single
    {4'd4, OP_W, 8'hD0, 32'h9, 32'h0},
    {4'd4, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd4, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd4, OP_R, 8'h24, 32'h0, 32'h100},
    {4'd4, OP_W, 8'h24, 32'h100, 32'h0},
    {4'd4, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd4, OP_T, 8'h00, 32'h1, 32'h0},
    {4'd4, OP_R, 8'h50, 32'h0, 32'h2},          // R4 no second hit
    {4'd4, OP_W, 8'h90, 32'h3, 32'h0},          // R4 rearm
    {4'd4, OP_T, 8'h00, 32'h1, 32'h0}
  };

  logic        clk, rst_n, bus_wr, bus_rd, irq;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  tick_en;
  int          n_run, n_fail;

  tmr_match_bank u_tmr_match_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input logic [3:0] m);
    tick_en = m;
    @(negedge clk);
    tick_en = '0;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    bus_wdata = '0; tick_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11", {31'b0, irq}, 32'h0);
    rchk("R11", 8'h40, 32'h0);
    rchk("R11", 8'h9C, 32'h0);
    rchk("R11", 8'hDC, 32'h0);
    rchk("R11", 8'h24, 32'h0);
    rchk("R11", 8'h28, 32'h0);
    rchk("R11", 8'h20, 32'h0);
    rchk("R11", 8'h3C, 32'h0);  // unmapped

    for (int i = 0; i < NV; i++) begin
      logic [31:0] d;
      logic [3:0]  rq;
      rq = VEC[i][77:74];
      case (VEC[i][73:72])
        OP_W: wr(VEC[i][71:64], VEC[i][63:32]);
        OP_T: tick(VEC[i][35:32]);
        OP_R: begin
          rd(VEC[i][71:64], d);
          chk($sformatf("R%0d vec%0d", rq, i), d, VEC[i][31:0]);
        end
        default: chk($sformatf("R%0d vec%0d irq", rq, i), {31'b0, irq}, VEC[i][31:0]);
      endcase
    end
    // R4 rearmed hit, R3 wrap on ch8
    rchk("R4", 8'h24, 32'h100);
    rchk("R3", 8'h50, 32'h0);
    wr(8'h24, 32'h100);
    wr(8'hD0, 32'h0);

    // R5 borrowed counter
    wr(8'h40, 32'h0);
    wr(8'h84, 32'h2);
    wr(8'hC0, 32'h1);
    tick(4'h1); tick(4'h1);
    rchk("R5", 8'h24, 32'h20);
    rchk("R5", 8'h44, 32'h0);
    wr(8'h24, 32'h20);
    wr(8'hC4, 32'h81);
    tick(4'h1); tick(4'h1);
    rchk("R5", 8'h44, 32'h2);
    rchk("R5", 8'h24, 32'h20);
    wr(8'h24, 32'h20);
    wr(8'hC0, 32'h0);
    wr(8'hC4, 32'h0);
    wr(8'h84, 32'h0);

    // R6 freeze
    wr(8'hD4, 32'h181);
    wr(8'h54, 32'h5);
    tick(4'h1);
    rchk("R6", 8'h54, 32'h5);
    wr(8'hD4, 32'h81);
    tick(4'h1);
    rchk("R6", 8'h54, 32'h6);

    // R7 capture
    wr(8'h50, 32'h1234);
    wr(8'hD4, 32'h200);
    rchk("R7", 8'h54, 32'h6);
    rchk("R7", 8'h20, 32'h1234);
    wr(8'h58, 32'h55);
    wr(8'hDC, 32'h0);
    rchk("R7", 8'h5C, 32'h0);
    rchk("R7", 8'h20, 32'h1234);
    wr(8'hDC, 32'h200);
    rchk("R7", 8'h5C, 32'h0);
    rchk("R7", 8'h20, 32'h55);

    // R8 enable gating
    wr(8'h28, 32'hFE0);
    wr(8'h40, 32'h0);
    wr(8'h80, 32'h1);
    wr(8'hC0, 32'h1);
    tick(4'h1);
    rchk("R8", 8'h24, 32'h0);
    chk("R8", {31'b0, irq}, 32'h0);
    wr(8'h28, 32'hFF0);
    wr(8'h80, 32'h2);
    tick(4'h1);
    chk("R8", {31'b0, irq}, 32'h1);
    wr(8'h24, 32'hFFFFFFFF);
    chk("R8", {31'b0, irq}, 32'h0);

    // R10 write beats pulse
    bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h100; tick_en = 4'h1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = '0;
    rchk("R10", 8'h40, 32'h100);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule